// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block moves single words between two independently clocked ports, one storage register per direction. The port A side loads mailbox 1, which the port B side reads. The port B side loads mailbox 2, which the port A side reads. Each register has an active-low full flag, kept in the writer's clock domain. A successful load drives the flag low. The flag stays low, and further loads are dropped, until the reader has taken the word and that news has crossed back into the writer's domain.

An access counts only when its port's chip select is low and its enable is high. On port A, the mailbox select input must also be high. On port B, the two-bit size code must be 2'b11. Load and acknowledge events cross between the domains as toggles through synchronizer chains of `SYNC_STAGES` flops. The data register is written only while its flag is high, so the data is stable whenever the far side samples it. A read that finds no unread word leaves the read data output at its last value and changes no flag.

Top module: `mbox_pair`

## Requirements
- R1: While rst_n is low and after its release, full1_n and full2_n are 1, and dout_a and dout_b are 0.
- R2: A port A write (cs_a_n=0, en_a=1, wr_a=1, mbx_sel_a=1) while full1_n is 1 stores din_a in mailbox 1, and full1_n is 0 after that clk_a edge.
- R3: A port A write while full1_n is 0 is dropped: the word later read on port B is the one stored first.
- R4: A port B read (cs_b_n=0, en_b=1, wr_b=0, size_b=2'b11) issued once a stored word has crossed puts that word on dout_b after the clk_b edge, and full1_n then returns to 1 within 16 clk_a cycles.
- R5: A port B write (cs_b_n=0, en_b=1, wr_b=1, size_b=2'b11) while full2_n is 1 stores din_b in mailbox 2, and full2_n is 0 after that clk_b edge.
- R6: A port B write while full2_n is 0 is dropped: the word later read on port A is the one stored first.
- R7: A port A read (cs_a_n=0, en_a=1, wr_a=0, mbx_sel_a=1) issued once a stored word has crossed puts mailbox 2 on dout_a, and full2_n then returns to 1 within 16 clk_b cycles.
- R8: An access with cs high, with en low, with mbx_sel_a=0 on port A, or with size_b other than 2'b11 on port B neither loads nor reads a mailbox: flags and read outputs do not change.
- R9: A read on a side that has no unread word leaves its dout at its previous value and changes no flag.
- R10: A full flag stays 0 for as long as the far side does not read, however long that is.
- R11: Words sent in both directions at once, with asynchronous clocks, arrive in order and none is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_a | input | 1 | Port A clock |
| cs_a_n | input | 1 | Port A chip select, active low |
| en_a | input | 1 | Port A enable, active high |
| wr_a | input | 1 | Port A direction: 1 write, 0 read |
| mbx_sel_a | input | 1 | Port A mailbox select |
| din_a | input | W | Port A write data |
| dout_a | output | W | Port A read data (last word from mailbox 2) |
| full1_n | output | 1 | Mailbox 1 full flag, active low, clk_a domain |
| clk_b | input | 1 | Port B clock |
| cs_b_n | input | 1 | Port B chip select, active low |
| en_b | input | 1 | Port B enable, active high |
| wr_b | input | 1 | Port B direction: 1 write, 0 read |
| size_b | input | 2 | Port B size code; 2'b11 selects the mailbox |
| din_b | input | W | Port B write data |
| dout_b | output | W | Port B read data (last word from mailbox 1) |
| full2_n | output | 1 | Mailbox 2 full flag, active low, clk_b domain |

## Verification
The assertions check two things on every edge of each clock. A qualified write with the flag high drops that flag on the next edge, and any fall of a flag must follow such a write. A read output moves only after a qualified read on its own port. The return of a flag after a read, the rejection of writes while a flag is low, the holding of the flag when no read comes, and the order of words under concurrent asynchronous traffic all depend on crossings between the two domains. Only the bench scenarios show those, with a scoreboard comparing every word that appears on either read port.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

   // Size code on port B that routes an access to the mailbox.
   localparam int unsigned MBOX_SIZE_W   = 2;
   localparam logic [MBOX_SIZE_W-1:0] MBOX_SIZE_SEL = 2'b11;

   // Decoded request of one port toward its mailbox pair.
   typedef struct packed {
      logic wr;
      logic rd;
   } mbox_req_t;

endpackage

// File: rtl/mbox_tgl_sync.sv
module mbox_tgl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_in,
   output logic pulse
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mbox_tgl_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], tgl_in};
         last_q  <= chain_q[STAGES-1];
      end
   end

   // One-cycle pulse for every change of the incoming toggle.
   assign pulse = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/mbox_wr_side.sv
module mbox_wr_side #(
   parameter int unsigned W      = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wdata,
   input  logic         ack_tgl,
   output logic         full_n,
   output logic [W-1:0] box,
   output logic         set_tgl
);

   logic ack_pulse;
   logic wr_take;

   mbox_tgl_sync #(.STAGES(STAGES)) i_ack_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tgl_in (ack_tgl),
      .pulse  (ack_pulse)
   );

   // Loads are accepted only while the register is empty.
   assign wr_take = wr_req & full_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         box     <= '0;
         full_n  <= 1'b1;
         set_tgl <= 1'b0;
      end else begin
         if (wr_take) begin
            box     <= wdata;
            full_n  <= 1'b0;
            set_tgl <= ~set_tgl;
         end else if (ack_pulse) begin
            full_n  <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mbox_rd_side.sv
module mbox_rd_side #(
   parameter int unsigned W      = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rd_req,
   input  logic [W-1:0] box,
   input  logic         set_tgl,
   output logic [W-1:0] rdata,
   output logic         ack_tgl
);

   logic set_pulse;
   logic pending_q;
   logic rd_take;

   mbox_tgl_sync #(.STAGES(STAGES)) i_set_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .tgl_in (set_tgl),
      .pulse  (set_pulse)
   );

   // A read with nothing pending leaves everything as it was.
   assign rd_take = rd_req & pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         rdata     <= '0;
         ack_tgl   <= 1'b0;
      end else begin
         if (rd_take) begin
            pending_q <= 1'b0;
            rdata     <= box;
            ack_tgl   <= ~ack_tgl;
         end else if (set_pulse) begin
            pending_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
   parameter int unsigned W      = 36,
   parameter int unsigned STAGES = 2
) (
   input  logic         rst_n,
   input  logic         clk_w,
   input  logic         wr_req,
   input  logic [W-1:0] wdata,
   output logic         full_n,
   input  logic         clk_r,
   input  logic         rd_req,
   output logic [W-1:0] rdata
);

   logic [W-1:0] box;
   logic         set_tgl;
   logic         ack_tgl;

   mbox_wr_side #(.W(W), .STAGES(STAGES)) i_wr (
      .clk     (clk_w),
      .rst_n   (rst_n),
      .wr_req  (wr_req),
      .wdata   (wdata),
      .ack_tgl (ack_tgl),
      .full_n  (full_n),
      .box     (box),
      .set_tgl (set_tgl)
   );

   mbox_rd_side #(.W(W), .STAGES(STAGES)) i_rd (
      .clk     (clk_r),
      .rst_n   (rst_n),
      .rd_req  (rd_req),
      .box     (box),
      .set_tgl (set_tgl),
      .rdata   (rdata),
      .ack_tgl (ack_tgl)
   );

endmodule

// File: rtl/mbox_pair.sv
module mbox_pair
   import mbox_pkg::*;
#(
   parameter int unsigned W           = 36,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic         rst_n,
   input  logic         clk_a,
   input  logic         cs_a_n,
   input  logic         en_a,
   input  logic         wr_a,
   input  logic         mbx_sel_a,
   input  logic [W-1:0] din_a,
   output logic [W-1:0] dout_a,
   output logic         full1_n,
   input  logic         clk_b,
   input  logic         cs_b_n,
   input  logic         en_b,
   input  logic         wr_b,
   input  logic [1:0]   size_b,
   input  logic [W-1:0] din_b,
   output logic [W-1:0] dout_b,
   output logic         full2_n
);

   generate
      if (W < 1) begin : g_bad_width
         $error("mbox_pair: W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("mbox_pair: SYNC_STAGES must be at least 2");
      end
   endgenerate

   mbox_req_t req_a;
   mbox_req_t req_b;
   logic      hit_a;
   logic      hit_b;

   assign hit_a     = ~cs_a_n & en_a & mbx_sel_a;
   assign hit_b     = ~cs_b_n & en_b & (size_b == MBOX_SIZE_SEL);
   assign req_a.wr  = hit_a &  wr_a;
   assign req_a.rd  = hit_a & ~wr_a;
   assign req_b.wr  = hit_b &  wr_b;
   assign req_b.rd  = hit_b & ~wr_b;

   // Mailbox 1: written on port A, read on port B.
   mbox_channel #(.W(W), .STAGES(SYNC_STAGES)) i_mbox1 (
      .rst_n  (rst_n),
      .clk_w  (clk_a),
      .wr_req (req_a.wr),
      .wdata  (din_a),
      .full_n (full1_n),
      .clk_r  (clk_b),
      .rd_req (req_b.rd),
      .rdata  (dout_b)
   );

   // Mailbox 2: written on port B, read on port A.
   mbox_channel #(.W(W), .STAGES(SYNC_STAGES)) i_mbox2 (
      .rst_n  (rst_n),
      .clk_w  (clk_b),
      .wr_req (req_b.wr),
      .wdata  (din_b),
      .full_n (full2_n),
      .clk_r  (clk_a),
      .rd_req (req_a.rd),
      .rdata  (dout_a)
   );

endmodule

// File: rtl/mbox_pair_chk.sv
module mbox_pair_chk #(
   parameter int unsigned W = 36
) (
   input logic         rst_n,
   input logic         clk_a,
   input logic         cs_a_n,
   input logic         en_a,
   input logic         wr_a,
   input logic         mbx_sel_a,
   input logic [W-1:0] dout_a,
   input logic         full1_n,
   input logic         clk_b,
   input logic         cs_b_n,
   input logic         en_b,
   input logic         wr_b,
   input logic [1:0]   size_b,
   input logic [W-1:0] dout_b,
   input logic         full2_n
);

   logic a_wr, a_rd, b_wr, b_rd;
   assign a_wr = !cs_a_n && en_a && mbx_sel_a && wr_a;
   assign a_rd = !cs_a_n && en_a && mbx_sel_a && !wr_a;
   assign b_wr = !cs_b_n && en_b && (size_b == 2'b11) && wr_b;
   assign b_rd = !cs_b_n && en_b && (size_b == 2'b11) && !wr_b;

   AST_FULL1_DROPS_ON_WRITE: assert property (@(posedge clk_a) disable iff (!rst_n)
      (a_wr && full1_n) |=> !full1_n); // R2

   AST_FULL1_FALL_NEEDS_WRITE: assert property (@(posedge clk_a) disable iff (!rst_n)
      $fell(full1_n) |-> $past(a_wr)); // R8

   AST_FULL2_DROPS_ON_WRITE: assert property (@(posedge clk_b) disable iff (!rst_n)
      (b_wr && full2_n) |=> !full2_n); // R5

   AST_FULL2_FALL_NEEDS_WRITE: assert property (@(posedge clk_b) disable iff (!rst_n)
      $fell(full2_n) |-> $past(b_wr)); // R8

   AST_DOUTA_HOLDS_NO_READ: assert property (@(posedge clk_a) disable iff (!rst_n)
      !a_rd |=> $stable(dout_a)); // R9

   AST_DOUTB_HOLDS_NO_READ: assert property (@(posedge clk_b) disable iff (!rst_n)
      !b_rd |=> $stable(dout_b)); // R9

endmodule

bind mbox_pair mbox_pair_chk #(.W(W)) i_mbox_pair_chk (
   .rst_n     (rst_n),
   .clk_a     (clk_a),
   .cs_a_n    (cs_a_n),
   .en_a      (en_a),
   .wr_a      (wr_a),
   .mbx_sel_a (mbx_sel_a),
   .dout_a    (dout_a),
   .full1_n   (full1_n),
   .clk_b     (clk_b),
   .cs_b_n    (cs_b_n),
   .en_b      (en_b),
   .wr_b      (wr_b),
   .size_b    (size_b),
   .dout_b    (dout_b),
   .full2_n   (full2_n)
);

// File: tb/test_mbox_pair.sv
module test_mbox_pair;

   localparam int W = 36;

   logic         rst_n = 1'b0;
   logic         clk_a = 1'b0;
   logic         clk_b = 1'b0;
   logic         cs_a_n = 1'b1, en_a = 1'b0, wr_a = 1'b0, mbx_sel_a = 1'b0;
   logic [W-1:0] din_a = '0;
   logic         cs_b_n = 1'b1, en_b = 1'b0, wr_b = 1'b0;
   logic [1:0]   size_b = 2'b00;
   logic [W-1:0] din_b = '0;
   logic [W-1:0] dout_a, dout_b;
   logic         full1_n, full2_n;

   always #5    clk_a = ~clk_a;   // 100 MHz
   always #6.5  clk_b = ~clk_b;   // unrelated port B clock

   mbox_pair #(.W(W), .SYNC_STAGES(2)) i_mbox_pair (
      .rst_n(rst_n), .clk_a(clk_a), .cs_a_n(cs_a_n), .en_a(en_a), .wr_a(wr_a),
      .mbx_sel_a(mbx_sel_a), .din_a(din_a), .dout_a(dout_a), .full1_n(full1_n),
      .clk_b(clk_b), .cs_b_n(cs_b_n), .en_b(en_b), .wr_b(wr_b), .size_b(size_b),
      .din_b(din_b), .dout_b(dout_b), .full2_n(full2_n)
   );

   int n_chk  = 0;
   int n_fail = 0;
   logic [W-1:0] exp_b[$];   // words expected on dout_b
   logic [W-1:0] exp_a[$];   // words expected on dout_a
   int got_a = 0, got_b = 0;
   logic [W-1:0] last_a = '0, last_b = '0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- drivers ----------------
   task automatic a_acc(input bit cs_n, input bit en, input bit wr, input bit sel, input logic [W-1:0] d);
      @(negedge clk_a);
      cs_a_n = cs_n; en_a = en; wr_a = wr; mbx_sel_a = sel; din_a = d;
      @(negedge clk_a);
      cs_a_n = 1'b1; en_a = 1'b0; wr_a = 1'b0; mbx_sel_a = 1'b0;
   endtask

   task automatic b_acc(input bit cs_n, input bit en, input bit wr, input logic [1:0] sz, input logic [W-1:0] d);
      @(negedge clk_b);
      cs_b_n = cs_n; en_b = en; wr_b = wr; size_b = sz; din_b = d;
      @(negedge clk_b);
      cs_b_n = 1'b1; en_b = 1'b0; wr_b = 1'b0; size_b = 2'b00;
   endtask

   task automatic a_send(input logic [W-1:0] d);   // accepted write, expected on B
      exp_b.push_back(d);
      a_acc(1'b0, 1'b1, 1'b1, 1'b1, d);
   endtask

   task automatic b_send(input logic [W-1:0] d);   // accepted write, expected on A
      exp_a.push_back(d);
      b_acc(1'b0, 1'b1, 1'b1, 2'b11, d);
   endtask

   task automatic a_read(); a_acc(1'b0, 1'b1, 1'b0, 1'b1, '0); endtask
   task automatic b_read(); b_acc(1'b0, 1'b1, 1'b0, 2'b11, '0); endtask

   task automatic idle_a(input int n); repeat (n) @(negedge clk_a); endtask
   task automatic idle_b(input int n); repeat (n) @(negedge clk_b); endtask

   // ---------------- monitors ----------------
   always @(negedge clk_b) begin
      if (rst_n && dout_b !== last_b) begin
         if (exp_b.size() == 0) chk(1'b0, "R9 unexpected dout_b change", dout_b, last_b);
         else begin
            logic [W-1:0] e;
            e = exp_b.pop_front();
            chk(dout_b === e, "R4 dout_b word", dout_b, e);
         end
         last_b = dout_b;
         got_b++;
      end
   end

   always @(negedge clk_a) begin
      if (rst_n && dout_a !== last_a) begin
         if (exp_a.size() == 0) chk(1'b0, "R9 unexpected dout_a change", dout_a, last_a);
         else begin
            logic [W-1:0] e;
            e = exp_a.pop_front();
            chk(dout_a === e, "R7 dout_a word", dout_a, e);
         end
         last_a = dout_a;
         got_a++;
      end
   end

   // ---------------- watchdog ----------------
   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      int t;
      idle_a(3);
      chk(full1_n === 1'b1 && full2_n === 1'b1, "R1 flags in reset", {full1_n, full2_n}, 2'b11);
      @(negedge clk_a); rst_n = 1'b1;
      idle_a(2);
      chk(full1_n === 1'b1 && full2_n === 1'b1, "R1 flags after reset", {full1_n, full2_n}, 2'b11);
      chk(dout_a === '0 && dout_b === '0, "R1 outputs after reset", dout_a | dout_b, '0);

      // R8: unqualified writes on both ports
      a_acc(1'b1, 1'b1, 1'b1, 1'b1, 36'h111111111);
      a_acc(1'b0, 1'b0, 1'b1, 1'b1, 36'h222222222);
      a_acc(1'b0, 1'b1, 1'b1, 1'b0, 36'h333333333);
      chk(full1_n === 1'b1, "R8 port A gated writes", full1_n, 1);
      b_acc(1'b1, 1'b1, 1'b1, 2'b11, 36'h444444444);
      b_acc(1'b0, 1'b0, 1'b1, 2'b11, 36'h555555555);
      b_acc(1'b0, 1'b1, 1'b1, 2'b10, 36'h666666666);
      chk(full2_n === 1'b1, "R8 port B gated writes", full2_n, 1);

      // R9: reads with nothing pending
      b_read(); a_read();
      chk(dout_b === '0 && full1_n === 1'b1, "R9 empty read port B", dout_b, '0);
      chk(dout_a === '0 && full2_n === 1'b1, "R9 empty read port A", dout_a, '0);

      // mailbox 1 path
      a_send(36'hA5A5A5A51);
      chk(full1_n === 1'b0, "R2 full1_n low after write", full1_n, 0);
      a_acc(1'b0, 1'b1, 1'b1, 1'b1, 36'hBADBADBAD);   // dropped
      chk(full1_n === 1'b0, "R3 full1_n stays low", full1_n, 0);
      idle_a(30);
      chk(full1_n === 1'b0, "R10 full1_n held without read", full1_n, 0);
      b_acc(1'b1, 1'b1, 1'b0, 2'b11, '0);             // R8 gated read
      b_acc(1'b0, 1'b1, 1'b0, 2'b01, '0);
      idle_a(16);
      chk(full1_n === 1'b0 && dout_b === '0, "R8 gated reads port B", dout_b, '0);
      b_read();
      idle_b(1);
      chk(got_b == 1, "R4 word delivered on port B", got_b, 1);
      t = 0;
      while (!full1_n && t < 16) begin @(negedge clk_a); t++; end
      chk(full1_n === 1'b1, "R4 full1_n returns high", full1_n, 1);
      b_read(); idle_b(2);
      chk(got_b == 1 && dout_b === 36'hA5A5A5A51, "R3 R9 no second word", dout_b, 36'hA5A5A5A51);

      // mailbox 2 path
      b_send(36'h0C3C3C3C2);
      chk(full2_n === 1'b0, "R5 full2_n low after write", full2_n, 0);
      b_acc(1'b0, 1'b1, 1'b1, 2'b11, 36'hDEADDEAD0);  // dropped
      chk(full2_n === 1'b0, "R6 full2_n stays low", full2_n, 0);
      idle_b(30);
      chk(full2_n === 1'b0, "R10 full2_n held without read", full2_n, 0);
      a_acc(1'b0, 1'b1, 1'b0, 1'b0, '0);              // R8 gated read
      idle_b(16);
      chk(full2_n === 1'b0 && dout_a === '0, "R8 gated read port A", dout_a, '0);
      a_read();
      idle_a(1);
      chk(got_a == 1, "R7 word delivered on port A", got_a, 1);
      t = 0;
      while (!full2_n && t < 16) begin @(negedge clk_b); t++; end
      chk(full2_n === 1'b1, "R7 full2_n returns high", full2_n, 1);
      a_read(); idle_a(2);
      chk(got_a == 1 && dout_a === 36'h0C3C3C3C2, "R6 R9 no second word", dout_a, 36'h0C3C3C3C2);

      // R11: concurrent traffic both ways
      fork
         begin
            for (int i = 0; i < 6; i++) begin
               while (!full1_n) @(negedge clk_a);
               a_send(36'h100000000 + 36'(i * 17 + 3));
               while (got_a < 2 + i) a_read();
            end
         end
         begin
            for (int i = 0; i < 6; i++) begin
               while (!full2_n) @(negedge clk_b);
               b_send(36'h200000000 + 36'(i * 29 + 5));
               while (got_b < 2 + i) b_read();
            end
         end
      join
      idle_a(4);
      chk(got_a == 7 && exp_a.size() == 0, "R11 all words on port A", got_a, 7);
      chk(got_b == 7 && exp_b.size() == 0, "R11 all words on port B", got_b, 7);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule